// File: doc/BRIEF.md
# Byte-Wide Non-Volatile Store Access Controller

This block connects a CPU's register bus to a 512-byte non-volatile data store, modelled here as on-chip registers. The CPU sees three registers: an address register, a data register and a control register. Through them it reads or writes one byte at a time. This store is a data space of its own, apart from the working RAM. Each access freezes the CPU for a fixed time through a stall output. A read stalls for four cycles and a write stalls for two. A write then goes on by itself for a parameterised number of cycles, and the CPU polls the busy bit to learn when the next byte may be written.

Writes are protected against accidental strobes. The control register carries an arm bit that lasts for a short window, and a write strobe is accepted only while the arm bit is already set. A sequencer with four named states does the timing. `ST_IDLE` goes to `ST_RD_STALL` when a read is accepted and to `ST_WR_STALL` when an armed write is accepted. `ST_RD_STALL` returns to `ST_IDLE` after four cycles and loads the data register. `ST_WR_STALL` moves to `ST_WR_BUSY` after two cycles. `ST_WR_BUSY` commits the byte and returns to `ST_IDLE` after `WRITE_CYCLES` cycles.

Top module: `nvb_ctrl`

## Requirements
- R1: The store holds 512 bytes addressed by a 9-bit address. A register write selects its target with `reg_sel`: 0 loads the address from `reg_wdata[8:0]`, 1 loads the data register from `reg_wdata[7:0]`, and 2 writes the control register, where bit 0 is the read strobe, bit 1 the write strobe and bit 2 the arm bit. `ctrl_q` shows {arm, write-busy, read-busy} on bits [2:0].
- R2: An accepted read strobe loads the data register with the byte at the current address in the last stall cycle. `ctrl_q[0]` is high while the read is in progress and then clears itself.
- R3: A read raises `cpu_stall` for exactly four cycles, starting in the cycle after the control register write.
- R4: An accepted write raises `cpu_stall` for exactly two cycles, starting in the cycle after the control register write.
- R5: Writing the control register with bit 2 set makes the arm bit visible for four cycles. The arm bit then clears itself.
- R6: A write strobe starts a write only if the arm bit is already set when the strobe is written, that is, within four cycles of arming. Any other write strobe is ignored and leaves the store unchanged, even one that sets the arm bit in the same register write. An accepted write uses up the arm.
- R7: After the write stall, the write runs on for `WRITE_CYCLES` more cycles, so `ctrl_q[1]` stays high for 2+`WRITE_CYCLES` cycles. The byte is committed at the end, and `ctrl_q[1]` then clears itself.
- R8: While an access is in progress, writes to all three registers are ignored. The address and data registers keep their values, and no read or arm is accepted.
- R9: Reset clears the control bits, the stall, and the address and data registers. It leaves the stored bytes unchanged, and a write cut off by reset does not commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe from the CPU |
| reg_sel | input | 2 | Register select: 0 address, 1 data, 2 control |
| reg_wdata | input | 9 | Register write data |
| addr_q | output | 9 | Address register |
| data_q | output | 8 | Data register |
| ctrl_q | output | 3 | Control bits {arm, write-busy, read-busy} |
| cpu_stall | output | 1 | Freezes the CPU while high |

## Verification
The hardest cases to reach from the ports are the edges of the arming window and a reset that lands in the middle of a self-timed write. The stimulus counts idle cycles after arming so that the strobe lands exactly on the fourth cycle, which must be accepted, and exactly on the fifth, which must be ignored. A read-back then shows whether the byte changed. For the reset case, reset is asserted while the write-busy bit is high, and the byte at that address is read back. It must still hold its value from before the write.

// File: rtl/nvb_pkg.sv
package nvb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_STALL,
        ST_WR_STALL,
        ST_WR_BUSY
    } nvb_state_e;

    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_DATA = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    localparam int CB_RD  = 0;
    localparam int CB_WR  = 1;
    localparam int CB_ARM = 2;

    localparam int RD_STALL_CYC = 4;
    localparam int WR_STALL_CYC = 2;
endpackage

// File: rtl/nvb_arm_guard.sv
module nvb_arm_guard #(
    parameter int WINDOW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic consume_i,
    output logic armed_o
);
    localparam int CW = $clog2(WINDOW + 1);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_o <= 1'b0;
            left_q  <= '0;
        end else if (consume_i) begin
            armed_o <= 1'b0;
            left_q  <= '0;
        end else if (set_i) begin
            armed_o <= 1'b1;
            left_q  <= CW'(WINDOW - 1);
        end else if (armed_o) begin
            if (left_q == '0) begin
                armed_o <= 1'b0;
            end else begin
                left_q <= left_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/nvb_store.sv
module nvb_store #(
    parameter int DEPTH = 512,
    parameter int DW    = 8
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [DW-1:0]            rdata
);
    logic [DW-1:0] cells [DEPTH];

    // No reset on purpose: contents survive rst_n.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/nvb_seq.sv
module nvb_seq
    import nvb_pkg::*;
#(
    parameter int WRITE_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    input  logic wr_req,
    output logic stall_o,
    output logic rd_busy_o,
    output logic wr_busy_o,
    output logic idle_o,
    output logic rd_done_o,
    output logic wr_commit_o
);
    localparam int CW = $clog2(WRITE_CYCLES + RD_STALL_CYC);

    nvb_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_req) begin
                    state_d = ST_WR_STALL;
                end else if (rd_req) begin
                    state_d = ST_RD_STALL;
                end
            end
            ST_RD_STALL: if (cnt_q == '0) state_d = ST_IDLE;
            ST_WR_STALL: if (cnt_q == '0) state_d = ST_WR_BUSY;
            ST_WR_BUSY:  if (cnt_q == '0) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                unique case (state_d)
                    ST_IDLE:     cnt_q <= '0;
                    ST_RD_STALL: cnt_q <= CW'(RD_STALL_CYC - 1);
                    ST_WR_STALL: cnt_q <= CW'(WR_STALL_CYC - 1);
                    ST_WR_BUSY:  cnt_q <= CW'(WRITE_CYCLES - 1);
                endcase
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    always_comb begin
        idle_o      = (state_q == ST_IDLE);
        rd_busy_o   = (state_q == ST_RD_STALL);
        wr_busy_o   = (state_q == ST_WR_STALL) || (state_q == ST_WR_BUSY);
        stall_o     = (state_q == ST_RD_STALL) || (state_q == ST_WR_STALL);
        rd_done_o   = (state_q == ST_RD_STALL) && (cnt_q == '0);
        wr_commit_o = (state_q == ST_WR_BUSY) && (cnt_q == '0);
    end
endmodule

// File: rtl/nvb_ctrl.sv
module nvb_ctrl
    import nvb_pkg::*;
#(
    parameter int DEPTH        = 512,
    parameter int DW           = 8,
    parameter int WRITE_CYCLES = 64,
    parameter int ARM_WINDOW   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic [1:0]               reg_sel,
    input  logic [$clog2(DEPTH)-1:0] reg_wdata,
    output logic [$clog2(DEPTH)-1:0] addr_q,
    output logic [DW-1:0]            data_q,
    output logic [2:0]               ctrl_q,
    output logic                     cpu_stall
);
    localparam int AW = $clog2(DEPTH);

    logic          idle, rd_busy, wr_busy, rd_done, wr_commit, armed;
    logic          ctrl_wr, wr_req, rd_req, arm_set;
    logic [DW-1:0] rd_byte;

    assign ctrl_wr = reg_wr && (reg_sel == SEL_CTRL) && idle;
    assign wr_req  = ctrl_wr && reg_wdata[CB_WR] && armed;
    assign rd_req  = ctrl_wr && reg_wdata[CB_RD];
    assign arm_set = ctrl_wr && reg_wdata[CB_ARM];

    nvb_arm_guard #(.WINDOW(ARM_WINDOW)) u_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (arm_set),
        .consume_i (wr_req),
        .armed_o   (armed)
    );

    nvb_seq #(.WRITE_CYCLES(WRITE_CYCLES)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_req      (rd_req),
        .wr_req      (wr_req),
        .stall_o     (cpu_stall),
        .rd_busy_o   (rd_busy),
        .wr_busy_o   (wr_busy),
        .idle_o      (idle),
        .rd_done_o   (rd_done),
        .wr_commit_o (wr_commit)
    );

    nvb_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk   (clk),
        .we    (wr_commit),
        .waddr (addr_q),
        .wdata (data_q),
        .raddr (addr_q),
        .rdata (rd_byte)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (reg_wr && (reg_sel == SEL_ADDR) && idle) begin
                addr_q <= reg_wdata[AW-1:0];
            end
            if (rd_done) begin
                data_q <= rd_byte;
            end else if (reg_wr && (reg_sel == SEL_DATA) && idle) begin
                data_q <= reg_wdata[DW-1:0];
            end
        end
    end

    assign ctrl_q = {armed, wr_busy, rd_busy};
endmodule

// File: rtl/nvb_ctrl_chk.sv
module nvb_ctrl_chk #(
    parameter int AW         = 9,
    parameter int DW         = 8,
    parameter int ARM_WINDOW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [1:0]    reg_sel,
    input logic [2:0]    ctrl_bits,
    input logic [AW-1:0] addr_q,
    input logic [DW-1:0] data_q,
    input logic [2:0]    ctrl_q,
    input logic          cpu_stall
);
    localparam int GW = $clog2(ARM_WINDOW + 2) + 1;

    logic          ctrl_write;
    logic [GW-1:0] arm_age;

    assign ctrl_write = reg_wr && (reg_sel == 2'd2);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_age <= '0;
        end else if (ctrl_write && ctrl_bits[2] && (ctrl_q[1:0] == 2'b00)) begin
            arm_age <= GW'(1);
        end else if (ctrl_q[2]) begin
            arm_age <= arm_age + 1'b1;
        end else begin
            arm_age <= '0;
        end
    end

    AST_RD_STALL_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q[0]) |-> cpu_stall ##1 cpu_stall ##1 cpu_stall ##1 cpu_stall ##1 !ctrl_q[0]); // R3

    AST_WR_STALL_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q[1]) |-> cpu_stall ##1 cpu_stall ##1 !cpu_stall); // R4

    AST_ARM_LIFETIME: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[2] |-> (arm_age <= GW'(ARM_WINDOW))); // R5

    AST_UNARMED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_write && ctrl_bits[1] && (ctrl_q == 3'b000)) |=> !ctrl_q[1]); // R6

    AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[1] |=> ($stable(addr_q) && $stable(data_q))); // R8

    AST_NO_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[1] && ctrl_write && ctrl_bits[0]) |=> !ctrl_q[0]); // R8
endmodule

bind nvb_ctrl nvb_ctrl_chk #(
    .AW         ($clog2(DEPTH)),
    .DW         (DW),
    .ARM_WINDOW (ARM_WINDOW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .ctrl_bits (reg_wdata[2:0]),
    .addr_q    (addr_q),
    .data_q    (data_q),
    .ctrl_q    (ctrl_q),
    .cpu_stall (cpu_stall)
);

// File: tb/nvb_ctrl_test.sv
module nvb_ctrl_test;
    localparam int WC = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [8:0] reg_wdata = '0;
    logic [8:0] addr_q;
    logic [7:0] data_q;
    logic [2:0] ctrl_q;
    logic       cpu_stall;

    int checks = 0;
    int fails  = 0;
    logic [7:0] shadow [512];

    always #10 clk = ~clk;

    nvb_ctrl #(.WRITE_CYCLES(WC)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .addr_q(addr_q), .data_q(data_q),
        .ctrl_q(ctrl_q), .cpu_stall(cpu_stall)
    );

    // {is_read, addr[8:0], data[7:0]}
    localparam logic [17:0] VEC [8] = '{
        {1'b0, 9'h000, 8'hA5}, {1'b0, 9'h1FF, 8'h3C}, {1'b0, 9'h0AA, 8'h5A},
        {1'b1, 9'h000, 8'hA5}, {1'b1, 9'h1FF, 8'h3C}, {1'b0, 9'h000, 8'h11},
        {1'b1, 9'h000, 8'h11}, {1'b1, 9'h0AA, 8'h5A}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [1:0] sel, input logic [8:0] v);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_read(input logic [8:0] a, output logic [7:0] d, output int ns);
        put(2'd0, a);
        put(2'd2, 9'b001);
        ns = 0;
        while (cpu_stall && ns < 50) begin ns++; @(negedge clk); end
        d = data_q;
    endtask

    task automatic do_write(input logic [8:0] a, input logic [7:0] d,
                            output int ns, output int nb);
        put(2'd0, a);
        put(2'd1, {1'b0, d});
        put(2'd2, 9'b100);
        put(2'd2, 9'b010);
        ns = 0;
        while (cpu_stall && ns < 50) begin ns++; @(negedge clk); end
        nb = ns;
        while (ctrl_q[1] && nb < 1000) begin nb++; @(negedge clk); end
        shadow[a] = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int ns, nb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        check("R9 ctrl after reset", ctrl_q, 0);
        check("R9 stall after reset", cpu_stall, 0);
        check("R9 addr after reset", addr_q, 0);
        check("R9 data after reset", data_q, 0);

        // Table walk: R1 R2 R3 R4 R7
        for (int i = 0; i < 8; i++) begin
            if (VEC[i][17]) begin
                do_read(VEC[i][16:8], d, ns);
                check("R2 read data", d, VEC[i][7:0]);
                check("R3 read stall cycles", ns, 4);
                check("R2 read bit cleared", ctrl_q[0], 0);
            end else begin
                do_write(VEC[i][16:8], VEC[i][7:0], ns, nb);
                check("R4 write stall cycles", ns, 2);
                check("R7 busy cycles", nb, 2 + WC);
                check("R6 arm consumed", ctrl_q[2], 0);
            end
        end
        check("R1 address register width", addr_q, 9'h0AA);
        put(2'd1, 9'h177);
        check("R1 data register takes low byte", data_q, 8'h77);

        // R5: arm visible four cycles
        put(2'd2, 9'b100);
        check("R5 arm set", ctrl_q[2], 1);
        repeat (3) @(negedge clk);
        check("R5 arm held 4th cycle", ctrl_q[2], 1);
        @(negedge clk);
        check("R5 arm expired", ctrl_q[2], 0);

        // R6/R5: strobe on last cycle of window accepted
        put(2'd0, 9'h010);
        put(2'd1, 9'h0C3);
        put(2'd2, 9'b100);
        repeat (3) @(negedge clk);
        put(2'd2, 9'b010);
        check("R6 strobe at window end accepted", ctrl_q[1], 1);
        while (ctrl_q[1]) @(negedge clk);
        shadow[9'h010] = 8'hC3;
        do_read(9'h010, d, ns);
        check("R7 committed byte", d, 8'hC3);

        // R6: strobe one cycle late ignored
        put(2'd1, 9'h03C);
        put(2'd2, 9'b100);
        repeat (4) @(negedge clk);
        put(2'd2, 9'b010);
        check("R6 late strobe ignored", ctrl_q[1], 0);
        check("R6 late strobe no stall", cpu_stall, 0);
        do_read(9'h010, d, ns);
        check("R6 store unchanged after late strobe", d, 8'hC3);

        // R6: unarmed strobe, and arm+strobe in one write
        put(2'd1, 9'h0EE);
        put(2'd2, 9'b010);
        check("R6 unarmed strobe ignored", ctrl_q[1], 0);
        put(2'd2, 9'b110);
        check("R6 same-write arm not enough", ctrl_q[1:0], 0);
        check("R6 same-write arm visible", ctrl_q[2], 1);
        repeat (5) @(negedge clk);
        do_read(9'h010, d, ns);
        check("R6 store unchanged after unarmed", d, 8'hC3);

        // R8: register writes ignored while busy
        put(2'd0, 9'h020);
        put(2'd1, 9'h044);
        put(2'd2, 9'b100);
        put(2'd2, 9'b010);
        repeat (2) @(negedge clk);
        put(2'd0, 9'h1AB);
        put(2'd1, 9'h0BB);
        put(2'd2, 9'b001);
        check("R8 addr frozen", addr_q, 9'h020);
        check("R8 data frozen", data_q, 8'h44);
        check("R8 read ignored", ctrl_q[0], 0);
        check("R8 no stall from ignored read", cpu_stall, 0);
        while (ctrl_q[1]) @(negedge clk);
        shadow[9'h020] = 8'h44;
        do_read(9'h020, d, ns);
        check("R8 committed original byte", d, 8'h44);

        // R9: reset keeps contents; reset mid-write aborts
        put(2'd0, 9'h1FF);
        put(2'd1, 9'h099);
        put(2'd2, 9'b100);
        put(2'd2, 9'b010);
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 ctrl cleared mid-write", ctrl_q, 0);
        do_read(9'h1FF, d, ns);
        check("R9 aborted write not committed", d, shadow[9'h1FF]);
        do_read(9'h0AA, d, ns);
        check("R9 contents kept over reset", d, shadow[9'h0AA]);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule